// File: doc/BRIEF.md
# Open-Page Bank Command Sequencer

This block sits between a request scheduler and a single DRAM bank. It receives column-level read or write requests and turns each into the shortest legal command sequence under an open-page policy. After every access the row stays latched in the sense amplifiers, so a later request to the same row costs one column command. A request to a precharged bank costs an activate and then the column command. A request to a different row costs a precharge, an activate and then the column command.

The sequencer records the row it last opened and, for each accepted request, reports whether the access was a hit, hit an empty bank or caused a conflict. A scheduler can use that report to steer its reordering. Three minimum spacings are enforced by down-counters: precharge to activate, activate to column, and column to precharge. Requests are accepted only when the first command of their sequence can go out in that same cycle, and at most one command leaves per cycle.

Top module: `bank_cmd_seq`

## Requirements
- R1: While reset is asserted and for at most two cycles after its release, req_ready is low and no command or status is produced. Afterwards req_ready is high with the bank empty.
- R2: A request accepted while the bank is empty produces, in the accept cycle, an activate (cmd_type 2) carrying the request row in cmd_addr. Exactly T_RCD cycles later it produces the column command carrying the request column.
- R3: A request to the open row produces only a column command in the accept cycle: read (cmd_type 3) when req_write is 0, write (cmd_type 4) when req_write is 1, with the column in cmd_addr.
- R4: A request to a row other than the open one produces a precharge (cmd_type 1) in the accept cycle. An activate to the new row follows exactly T_RP cycles later, and the column command exactly T_RCD cycles after that.
- R5: A conflicting request is accepted in the first cycle that is at least T_RTP cycles after the last column command and not earlier than its presentation.
- R6: From the accept cycle of an empty or conflict request until its column command, req_ready stays low, and the required command spacings are never violated.
- R7: stat_valid is high exactly in each accept cycle, with stat_kind 1 for a hit, 2 for an empty bank and 3 for a conflict.
- R8: Requests to the open row presented back to back are accepted in consecutive cycles, so an eight-column block moves in eight consecutive command cycles.
- R9: After any empty or conflict sequence the new row is the open row, so the next request to it is classed as a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can start its sequence this cycle |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_write | input | 1 | 1 for write, 0 for read |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_type | output | 3 | 0 none, 1 precharge, 2 activate, 3 read, 4 write |
| cmd_addr | output | max(ROW_W,COL_W) | Row for activate, column for read/write, zero for precharge |
| stat_valid | output | 1 | Row-buffer outcome valid (accept cycle) |
| stat_kind | output | 2 | 1 hit, 2 empty, 3 conflict |

## Verification
The bench builds the block with ROW_W=6, COL_W=5, T_RP=3, T_RCD=2 and T_RTP=4. The three spacings are all different, so a counter wired to the wrong timing edge shifts a command by a detectable number of cycles. A small row width and a random row choice among four values give a frequent mix of hits and conflicts. A T_RTP longer than T_RCD makes a conflict that arrives right after a column command wait, which exercises the delayed acceptance.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } bank_cmd_e;

  typedef enum logic [1:0] {
    KIND_NONE     = 2'd0,
    KIND_HIT      = 2'd1,
    KIND_EMPTY    = 2'd2,
    KIND_CONFLICT = 2'd3
  } row_kind_e;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_OPEN  = 2'd1,
    ST_PRECH = 2'd2,
    ST_ACTIV = 2'd3
  } bank_state_e;

  localparam int unsigned NUM_GAPS = 3;
  localparam int unsigned GAP_RP   = 0;
  localparam int unsigned GAP_RCD  = 1;
  localparam int unsigned GAP_RTP  = 2;

endpackage

// File: rtl/bank_gap_timer.sv
module bank_gap_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic clear
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? RELOAD : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign clear = (cnt_q == '0);
endmodule

// File: rtl/bank_row_track.sv
module bank_row_track #(
  parameter int unsigned ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] open_row_in,
  input  logic [ROW_W-1:0] probe_row,
  output logic             open_valid,
  output logic             probe_hit
);
  logic [ROW_W-1:0] row_q;
  logic             valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row_q <= '0;
    else if (open_en) row_q <= open_row_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    valid_q <= 1'b0;
    else if (open_en || close_en)  valid_q <= open_en;
  end

  assign open_valid = valid_q;
  assign probe_hit  = valid_q && (probe_row == row_q);
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bank_seq_pkg::*;
#(
  parameter int unsigned ROW_W = 14,
  parameter int unsigned COL_W = 10,
  parameter int unsigned T_RP  = 4,
  parameter int unsigned T_RCD = 4,
  parameter int unsigned T_RTP = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [ROW_W-1:0]                       req_row,
  input  logic [COL_W-1:0]                       req_col,
  input  logic                                   req_write,
  output logic                                   cmd_valid,
  output logic [2:0]                             cmd_type,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmd_addr,
  output logic                                   stat_valid,
  output logic [1:0]                             stat_kind
);
  localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int unsigned GAP_LIMITS [NUM_GAPS] = '{T_RP, T_RCD, T_RTP};

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       run_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign run_n = rst_pipe[1];

  bank_state_e      state_q, state_d;
  logic [ROW_W-1:0] pend_row_q;
  logic [COL_W-1:0] pend_col_q;
  logic             pend_wr_q;
  logic             pend_ld;

  logic [NUM_GAPS-1:0] gap_load, gap_clear;
  logic                act_go, pre_go, col_go;
  logic [ROW_W-1:0]    act_row;
  logic                row_hit, row_open;

  bank_cmd_e cmd_k;
  row_kind_e kind;
  logic      fire;

  assign gap_load[GAP_RP]  = pre_go;
  assign gap_load[GAP_RCD] = act_go;
  assign gap_load[GAP_RTP] = col_go;

  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
    bank_gap_timer #(.LIMIT(GAP_LIMITS[g])) u_timer (
      .clk   (clk),
      .rst_n (run_n),
      .load  (gap_load[g]),
      .clear (gap_clear[g])
    );
  end

  bank_row_track #(.ROW_W(ROW_W)) u_rows (
    .clk         (clk),
    .rst_n       (run_n),
    .open_en     (act_go),
    .close_en    (pre_go),
    .open_row_in (act_row),
    .probe_row   (req_row),
    .open_valid  (row_open),
    .probe_hit   (row_hit)
  );

  // next-state and command selection
  always_comb begin
    state_d   = state_q;
    req_ready = 1'b0;
    cmd_valid = 1'b0;
    cmd_k     = CMD_NOP;
    cmd_addr  = '0;
    kind      = KIND_NONE;
    act_go    = 1'b0;
    pre_go    = 1'b0;
    col_go    = 1'b0;
    pend_ld   = 1'b0;
    act_row   = pend_row_q;
    fire      = 1'b0;
    unique case (state_q)
      ST_EMPTY: begin
        req_ready = run_n && gap_clear[GAP_RP] && !row_open;
        fire      = req_valid && req_ready;
        if (fire) begin
          kind      = KIND_EMPTY;
          cmd_valid = 1'b1;
          cmd_k     = CMD_ACT;
          cmd_addr  = ADDR_W'(req_row);
          act_go    = 1'b1;
          act_row   = req_row;
          pend_ld   = 1'b1;
          state_d   = ST_ACTIV;
        end
      end
      ST_OPEN: begin
        req_ready = row_hit ? gap_clear[GAP_RCD] : gap_clear[GAP_RTP];
        fire      = req_valid && req_ready;
        if (fire && row_hit) begin
          kind      = KIND_HIT;
          cmd_valid = 1'b1;
          cmd_k     = req_write ? CMD_WR : CMD_RD;
          cmd_addr  = ADDR_W'(req_col);
          col_go    = 1'b1;
        end else if (fire) begin
          kind      = KIND_CONFLICT;
          cmd_valid = 1'b1;
          cmd_k     = CMD_PRE;
          pre_go    = 1'b1;
          pend_ld   = 1'b1;
          state_d   = ST_PRECH;
        end
      end
      ST_PRECH: begin
        if (gap_clear[GAP_RP]) begin
          cmd_valid = 1'b1;
          cmd_k     = CMD_ACT;
          cmd_addr  = ADDR_W'(pend_row_q);
          act_go    = 1'b1;
          state_d   = ST_ACTIV;
        end
      end
      ST_ACTIV: begin
        if (gap_clear[GAP_RCD]) begin
          cmd_valid = 1'b1;
          cmd_k     = pend_wr_q ? CMD_WR : CMD_RD;
          cmd_addr  = ADDR_W'(pend_col_q);
          col_go    = 1'b1;
          state_d   = ST_OPEN;
        end
      end
      default: state_d = ST_EMPTY;
    endcase
  end

  assign cmd_type   = cmd_k;
  assign stat_valid = fire;
  assign stat_kind  = kind;

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) state_q <= ST_EMPTY;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      pend_row_q <= '0;
      pend_col_q <= '0;
      pend_wr_q  <= 1'b0;
    end else if (pend_ld) begin
      pend_row_q <= req_row;
      pend_col_q <= req_col;
      pend_wr_q  <= req_write;
    end
  end
endmodule

// File: rtl/bank_cmd_seq_chk.sv
module bank_cmd_seq_chk #(
  parameter int unsigned T_RP  = 4,
  parameter int unsigned T_RCD = 4,
  parameter int unsigned T_RTP = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       cmd_valid,
  input logic [2:0] cmd_type,
  input logic       stat_valid,
  input logic [1:0] stat_kind
);
  localparam int unsigned TMAX = (T_RP > T_RCD) ? ((T_RP > T_RTP) ? T_RP : T_RTP)
                                                : ((T_RCD > T_RTP) ? T_RCD : T_RTP);
  localparam int unsigned SW = $clog2(TMAX + 1) + 1;
  localparam logic [SW-1:0] SAT_RP  = SW'(T_RP);
  localparam logic [SW-1:0] SAT_RCD = SW'(T_RCD);
  localparam logic [SW-1:0] SAT_RTP = SW'(T_RTP);

  logic is_pre, is_act, is_col;
  assign is_pre = cmd_valid && (cmd_type == 3'd1);
  assign is_act = cmd_valid && (cmd_type == 3'd2);
  assign is_col = cmd_valid && ((cmd_type == 3'd3) || (cmd_type == 3'd4));

  logic [SW-1:0] since_pre, since_act, since_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre <= SAT_RP;
      since_act <= SAT_RCD;
      since_col <= SAT_RTP;
    end else begin
      since_pre <= is_pre ? SW'(1) : ((since_pre < SAT_RP)  ? since_pre + 1'b1 : since_pre);
      since_act <= is_act ? SW'(1) : ((since_act < SAT_RCD) ? since_act + 1'b1 : since_act);
      since_col <= is_col ? SW'(1) : ((since_col < SAT_RTP) ? since_col + 1'b1 : since_col);
    end
  end

  // R4 / R6: precharge-to-activate spacing
  p_rp_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (since_pre >= SAT_RP));

  // R2 / R6: activate-to-column spacing
  p_rcd_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (since_act >= SAT_RCD));

  // R5: column-to-precharge spacing
  p_rtp_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (since_col >= SAT_RTP));

  // R7: status only on an accepted request, with a defined kind
  p_stat_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (req_valid && req_ready && (stat_kind != 2'd0)));

  // R6: every accepted request starts a command in the same cycle
  p_accept_issues_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> cmd_valid);

  // R6: after a precharge or activate the bank is busy next cycle
  p_busy_after_rowcmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre || is_act) |=> !req_ready);

  // R3: a hit is served by a column command alone
  p_hit_is_column_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && (stat_kind == 2'd1)) |-> is_col);

  // R4: a conflict starts with a precharge
  p_conflict_precharges_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && (stat_kind == 2'd3)) |-> is_pre);
endmodule

bind bank_cmd_seq bank_cmd_seq_chk #(
  .T_RP  (T_RP),
  .T_RCD (T_RCD),
  .T_RTP (T_RTP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .cmd_valid  (cmd_valid),
  .cmd_type   (cmd_type),
  .stat_valid (stat_valid),
  .stat_kind  (stat_kind)
);

// File: tb/bank_cmd_seq_tb.sv
`timescale 1ns/1ps
module bank_cmd_seq_tb;
  localparam int unsigned ROW_W  = 6;
  localparam int unsigned COL_W  = 5;
  localparam int unsigned T_RP   = 3;
  localparam int unsigned T_RCD  = 2;
  localparam int unsigned T_RTP  = 4;
  localparam int unsigned ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;
  logic              req_write;
  logic              cmd_valid;
  logic [2:0]        cmd_type;
  logic [ADDR_W-1:0] cmd_addr;
  logic              stat_valid;
  logic [1:0]        stat_kind;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  bit m_open = 1'b0;
  int m_row  = 0;
  int m_last = -100;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bank_cmd_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_RTP(T_RTP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_addr(cmd_addr),
    .stat_valid(stat_valid), .stat_kind(stat_kind)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int col_code(input bit wr);
    return wr ? 4 : 3;
  endfunction

  function automatic int expect_kind(input int row);
    if (!m_open) return 2;
    return (row == m_row) ? 1 : 3;
  endfunction

  task automatic wait_cmd(input int etype, input int eaddr, input int from, input int gap,
                          input string tag, output int at);
    bit quiet = 1'b1;
    int g = 0;
    do begin
      @(negedge clk);
      g++;
      if (req_ready || stat_valid) quiet = 1'b0;
    end while (!cmd_valid && g < 50);
    at = cyc;
    chk(cmd_valid && int'(cmd_type) == etype, tag, int'(cmd_type), etype);
    chk(int'(cmd_addr) == eaddr, {tag, " address"}, int'(cmd_addr), eaddr);
    chk(at - from == gap, {tag, " spacing"}, at - from, gap);
    chk(quiet, "R6 no accept or status while sequence pending", int'(quiet), 1);
  endtask

  task automatic do_req(input int row, input int col, input bit wr, input int idle);
    int ek, pres, acc, guard, exp_acc, t_act, t_col;
    for (int i = 0; i < idle; i++) begin
      @(posedge clk); #1;
    end
    req_row   = ROW_W'(row);
    req_col   = COL_W'(col);
    req_write = wr;
    req_valid = 1'b1;
    pres      = cyc;
    ek        = expect_kind(row);
    @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    acc = cyc;
    chk(stat_valid && int'(stat_kind) == ek, "R7 status kind", int'(stat_kind), ek);
    if (ek == 1) begin
      chk(acc == pres, "R8 hit accepted without delay", acc, pres);
      chk(cmd_valid && int'(cmd_type) == col_code(wr), "R3 hit column command",
          int'(cmd_type), col_code(wr));
      chk(int'(cmd_addr) == col, "R3 hit column address", int'(cmd_addr), col);
      m_last = acc;
    end else if (ek == 2) begin
      chk(cmd_valid && int'(cmd_type) == 2, "R2 activate on empty bank", int'(cmd_type), 2);
      chk(int'(cmd_addr) == row, "R2 activate row", int'(cmd_addr), row);
    end else begin
      exp_acc = (pres > m_last + int'(T_RTP)) ? pres : m_last + int'(T_RTP);
      chk(acc == exp_acc, "R5 conflict accept cycle", acc, exp_acc);
      chk(cmd_valid && int'(cmd_type) == 1, "R4 precharge on conflict", int'(cmd_type), 1);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (ek == 3) begin
      wait_cmd(2, row, acc, T_RP, "R4 activate after precharge", t_act);
      wait_cmd(col_code(wr), col, t_act, T_RCD, "R4 column after activate", t_col);
      m_last = t_col;
      @(posedge clk); #1;
    end else if (ek == 2) begin
      wait_cmd(col_code(wr), col, acc, T_RCD, "R2 column after activate", t_col);
      m_last = t_col;
      @(posedge clk); #1;
    end
    m_open = 1'b1;
    m_row  = row;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t0;
    void'($urandom(32'd7411));
    rst_n = 1'b0; req_valid = 1'b0; req_row = '0; req_col = '0; req_write = 1'b0;
    repeat (3) @(negedge clk);
    chk(!req_ready, "R1 not ready in reset", int'(req_ready), 0);
    chk(!cmd_valid && !stat_valid, "R1 quiet in reset", int'(cmd_valid), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
    chk(!cmd_valid && !stat_valid, "R1 no command after reset", int'(cmd_valid), 0);
    @(posedge clk); #1;

    // R2 first access to an empty bank, R9 then a hit on that row
    do_req(5, 3, 1'b0, 0);
    // R8 eight-column block on the open row
    t0 = cyc;
    for (int c = 0; c < 8; c++) do_req(5, c, 1'b0, 0);
    chk(cyc - t0 == 8, "R8 block in eight cycles", cyc - t0, 8);
    // R3 write hit
    do_req(5, 17, 1'b1, 0);
    // R4 / R5 conflict right after a column command: must wait
    do_req(9, 2, 1'b1, 0);
    // R9 new row is now open
    do_req(9, 30, 1'b0, 0);
    // R5 conflict after a long idle: no wait
    do_req(63, 31, 1'b0, 8);
    do_req(0, 0, 1'b1, 1);

    for (int n = 0; n < 300; n++) begin
      do_req(int'($urandom_range(0, 3)), int'($urandom_range(0, 31)),
             bit'($urandom_range(0, 1)), int'($urandom_range(0, 5)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule